// File: doc/BRIEF.md
# External Interrupt Edge Detector and Request Source Selector

This block turns activity on six asynchronous external interrupt pins into per-slot interrupt request flags. Each pin is brought into the clock domain by a two-flop synchronizer. A third flop holds the previous synchronized value, and comparing the two finds rising and falling edges. A pin either fires on one programmable edge, picked by its slot's polarity bit, or on both edges when its both-edge mode bit is set.

The block holds eight request slots. Slots 0 to 3 belong to pins 0 to 3. Slots 4 and 5 are shared: each takes its events either from a serial-channel pulse input or from pin 4 or pin 5. Slots 6 and 7 take their events either from a timer pulse or from a UART bus-collision pulse. Software reads and writes a small register file that holds the both-edge mode bits, the four source-select bits, and one polarity bit and one request flag per slot. A flag stays set until software writes 0 to it or the matching acknowledge input is pulsed.

Changing a source-select bit raises a spurious request on that slot, so software clears the flag after the switch. A configuration-error output flags polarity settings that the edge modes do not allow. Priority resolution, vector fetch and the peripherals that produce the pulses are outside this block.

Top module: `ext_irq_selector`

## Requirements
- R1: After reset, all registers read 0, every request flag is 0 and `cfg_err` is 0.
- R2: The slot register at address 2+k holds the request flag in bit 0 and the polarity bit in bit 1. In single-edge mode a pin sets its slot's flag on a falling edge when polarity is 0 and on a rising edge when polarity is 1. The opposite edge sets nothing. The flag is visible after the third rising clock edge that follows the pin change.
- R3: Bits 0 to 5 of the mode register at address 0 select both-edge mode for pins 0 to 5. In that mode both edges of the pin set the flag.
- R4: `cfg_err` is 1 exactly when a pin in both-edge mode has its slot polarity at 1, or when slot 4 or 5 has its serial source selected and its polarity at 1.
- R5: Mode register bit 6 picks the source of slot 4 (0: `ser_pulse[0]`, 1: pin 4). Bit 7 picks the source of slot 5 (0: `ser_pulse[1]`, 1: pin 5). The source that is not selected has no effect. A selected pulse sets the flag on the next clock edge.
- R6: Bit 6 of the alternate-select register at address 1 picks the source of slot 6 (0: `tmr_pulse[0]`, 1: `bcol_pulse[0]`). Bit 7 picks the source of slot 7 (0: `tmr_pulse[1]`, 1: `bcol_pulse[1]`). The source that is not selected has no effect.
- R7: Bits 5 to 0 of the alternate-select register ignore writes and read 0. Addresses 10 to 15 read 0.
- R8: A request flag holds until a slot-register write with bit 0 equal to 0, or a pulse on `ack[k]`, clears it. Writing 1 to bit 0 neither sets nor clears the flag.
- R9: When an event and a clear reach a slot in the same cycle, the flag ends up set.
- R10: A write that changes a source-select bit sets the request flag of the slot that bit controls. Writing the same value again sets nothing.
- R11: Each pin edge produces exactly one request. A pin held at a level after its edge does not set the flag again once the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| ser_pulse | input | 2 | Serial-channel event pulses for slots 4 and 5 |
| tmr_pulse | input | 2 | Timer event pulses for slots 6 and 7 |
| bcol_pulse | input | 2 | UART bus-collision event pulses for slots 6 and 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ack | input | 8 | Per-slot acknowledge pulse, clears the flag |
| req | output | 8 | Per-slot interrupt request flags |
| cfg_err | output | 1 | Illegal polarity and edge-mode combination |

## Verification
The assertions assume that the pulse inputs and the acknowledges are synchronous to the clock and last one cycle. They also assume that a write clearing a flag and a new event on that slot are independent, so that either can arrive in any cycle. The stimulus raises every pulse for exactly one cycle and moves a pin only after its previous edge has cleared the synchronizer. It raises an event together with a clear only in the set-wins scenario, and it sets a disallowed polarity only in the cycles meant to show `cfg_err`.

// File: rtl/irq_sel_pkg.sv
// Package: shared sizes, register addresses and slot numbering for the
// external interrupt selector. Assumes exactly six pins and eight slots.
package irq_sel_pkg;
    localparam int PIN_CNT   = 6;   // external interrupt pins
    localparam int SLOT_CNT  = 8;   // request slots
    localparam int DIRECT_CNT = 4;  // pins with a slot of their own
    localparam int SHARE_CNT = 2;   // shared pin/serial slots (and timer/collision slots)
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;

    localparam int ADR_MODE   = 0;  // both-edge bits [5:0], pin select [7:6]
    localparam int ADR_ALTSEL = 1;  // timer/collision select [7:6]
    localparam int ADR_SLOT0  = 2;  // slot k at ADR_SLOT0 + k

    localparam int SL_SHARE0 = DIRECT_CNT;             // first pin/serial slot
    localparam int SL_ALT0   = DIRECT_CNT + SHARE_CNT; // first timer/collision slot

    localparam int SEL_LSB = DATA_W - SHARE_CNT;       // select field position
endpackage

// File: rtl/pin_edge_sync.sv
// Module: pin_edge_sync
// Brings each asynchronous pin into the clock domain with two flops, keeps
// one more flop of history and reports single-cycle rise and fall strobes.
// Assumes the pins may change at any time relative to clk.
module pin_edge_sync #(
    parameter int N_PIN = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_in,
    output logic [N_PIN-1:0] rise,
    output logic [N_PIN-1:0] fall
);
    localparam int HIST = SYNC_STAGES + 1;

    for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pin
        logic [HIST-1:0] shr;

        // Shift the pin through the synchronizer and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) shr <= '0;
            else        shr <= {shr[HIST-2:0], pin_in[gi]};
        end

        assign rise[gi] = shr[HIST-2] & ~shr[HIST-1];
        assign fall[gi] = ~shr[HIST-2] & shr[HIST-1];
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the both-edge mode bits, the source-select bits and the per-slot
// polarity bits. Produces the write-side flag clears, the spurious set on
// a source switch and the configuration error. Assumes a single write port.
module irq_cfg_regs
    import irq_sel_pkg::*;
#(
    parameter int N_PIN  = PIN_CNT,
    parameter int N_SLOT = SLOT_CNT,
    parameter int N_SH   = SHARE_CNT,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [N_PIN-1:0]  both_mode,
    output logic [N_SH-1:0]   pin_sel,
    output logic [N_SH-1:0]   alt_sel,
    output logic [N_SLOT-1:0] pol,
    output logic [N_SLOT-1:0] wr_clr,
    output logic [N_SLOT-1:0] sel_flip,
    output logic              cfg_err
);
    localparam int SL_LSB = DW - N_SH;

    logic mode_we, alt_we;
    logic [N_SH-1:0] pin_sel_new, alt_sel_new;

    assign mode_we     = wr_en && (wr_addr == AW'(ADR_MODE));
    assign alt_we      = wr_en && (wr_addr == AW'(ADR_ALTSEL));
    assign pin_sel_new = wr_data[SL_LSB +: N_SH];
    assign alt_sel_new = wr_data[SL_LSB +: N_SH];

    // Mode register: both-edge bits and pin/serial select bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_mode <= '0;
            pin_sel   <= '0;
        end else if (mode_we) begin
            both_mode <= wr_data[N_PIN-1:0];
            pin_sel   <= pin_sel_new;
        end
    end

    // Alternate-select register: only the upper select bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      alt_sel <= '0;
        else if (alt_we) alt_sel <= alt_sel_new;
    end

    // Per-slot polarity bit and write-side clear strobe.
    for (genvar gk = 0; gk < N_SLOT; gk++) begin : g_slot
        logic slot_we;
        assign slot_we    = wr_en && (wr_addr == AW'(ADR_SLOT0 + gk));
        assign wr_clr[gk] = slot_we && !wr_data[0];

        // Capture the polarity bit on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)       pol[gk] <= 1'b0;
            else if (slot_we) pol[gk] <= wr_data[1];
        end
    end

    // A changed select bit raises a spurious request on its slot.
    always_comb begin
        sel_flip = '0;
        for (int j = 0; j < N_SH; j++) begin
            sel_flip[SL_SHARE0 + j] = mode_we && (pin_sel_new[j] != pin_sel[j]);
            sel_flip[SL_ALT0 + j]   = alt_we  && (alt_sel_new[j] != alt_sel[j]);
        end
    end

    // Flag polarity settings that the chosen edge mode or source forbids.
    always_comb begin
        cfg_err = |(both_mode & pol[N_PIN-1:0]);
        for (int j = 0; j < N_SH; j++)
            cfg_err = cfg_err | (!pin_sel[j] && pol[SL_SHARE0 + j]);
    end

    // The mode register takes the written both-edge bits.
    assert_mode_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (both_mode == $past(wr_data[N_PIN-1:0])));

    // The error output only moves after a register write.
    assert_err_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en)) |-> $stable(cfg_err));
endmodule

// File: rtl/req_flag_bank.sv
// Module: req_flag_bank
// One sticky request flag per slot. Set has priority over clear.
// Assumes set and clear strobes are single-cycle and synchronous.
module req_flag_bank #(
    parameter int N_SLOT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] set_ev,
    input  logic [N_SLOT-1:0] clr_ev,
    output logic [N_SLOT-1:0] flag
);
    for (genvar gk = 0; gk < N_SLOT; gk++) begin : g_flag
        // Update the flag with set winning over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            flag[gk] <= 1'b0;
            else if (set_ev[gk])   flag[gk] <= 1'b1;
            else if (clr_ev[gk])   flag[gk] <= 1'b0;
        end

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[gk] |=> flag[gk]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_ev[gk] && !set_ev[gk]) |=> !flag[gk]);

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_ev[gk] && !set_ev[gk]) |=> (flag[gk] == $past(flag[gk])));
    end
endmodule

// File: rtl/ext_irq_selector.sv
// Module: ext_irq_selector (top)
// Edge detection on six external pins, source selection for the shared
// slots, request flags and the register read path. Assumes pulse inputs
// and acknowledges are synchronous single-cycle strobes.
module ext_irq_selector
    import irq_sel_pkg::*;
#(
    parameter int N_PIN  = PIN_CNT,
    parameter int N_SLOT = SLOT_CNT,
    parameter int N_SH   = SHARE_CNT,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIN-1:0]  pin_in,
    input  logic [N_SH-1:0]   ser_pulse,
    input  logic [N_SH-1:0]   tmr_pulse,
    input  logic [N_SH-1:0]   bcol_pulse,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [N_SLOT-1:0] ack,
    output logic [N_SLOT-1:0] req,
    output logic              cfg_err
);
    localparam int SW = $clog2(N_SLOT);

    logic [N_PIN-1:0]  rise, fall, pin_ev, both_mode;
    logic [N_SH-1:0]   pin_sel, alt_sel;
    logic [N_SLOT-1:0] pol, wr_clr, sel_flip, slot_ev;
    logic [SW-1:0]     rd_slot;

    pin_edge_sync #(.N_PIN(N_PIN), .SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    irq_cfg_regs #(.N_PIN(N_PIN), .N_SLOT(N_SLOT), .N_SH(N_SH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .both_mode(both_mode), .pin_sel(pin_sel), .alt_sel(alt_sel), .pol(pol),
        .wr_clr(wr_clr), .sel_flip(sel_flip), .cfg_err(cfg_err)
    );

    // Pick the active edge of each pin from its mode and polarity.
    for (genvar gi = 0; gi < N_PIN; gi++) begin : g_pev
        assign pin_ev[gi] = both_mode[gi] ? (rise[gi] | fall[gi])
                                          : (pol[gi] ? rise[gi] : fall[gi]);
    end

    // Dedicated slots follow their own pin.
    for (genvar gd = 0; gd < DIRECT_CNT; gd++) begin : g_direct
        assign slot_ev[gd] = pin_ev[gd];
    end

    // Shared slots: pin or serial, and timer or bus collision.
    for (genvar gs = 0; gs < N_SH; gs++) begin : g_share
        assign slot_ev[SL_SHARE0 + gs] = pin_sel[gs] ? pin_ev[DIRECT_CNT + gs] : ser_pulse[gs];
        assign slot_ev[SL_ALT0 + gs]   = alt_sel[gs] ? bcol_pulse[gs] : tmr_pulse[gs];
    end

    req_flag_bank #(.N_SLOT(N_SLOT)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_ev(slot_ev | sel_flip), .clr_ev(wr_clr | ack), .flag(req)
    );

    assign rd_slot = SW'(rd_addr - AW'(ADR_SLOT0));

    // Register read mux; unmapped addresses and unused bits read 0.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADR_MODE))
            rd_data = DW'({pin_sel, both_mode});
        else if (rd_addr == AW'(ADR_ALTSEL))
            rd_data = DW'(alt_sel) << (DW - N_SH);
        else if (rd_addr >= AW'(ADR_SLOT0) && rd_addr < AW'(ADR_SLOT0 + N_SLOT))
            rd_data = DW'({pol[rd_slot], req[rd_slot]});
    end

    // A selected serial pulse always raises its slot on the next edge.
    assert_serial_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_sel[0] && ser_pulse[0]) |=> req[SL_SHARE0]);

    // A selected timer pulse always raises its slot on the next edge.
    assert_timer_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_sel[0] && tmr_pulse[0]) |=> req[SL_ALT0]);
endmodule

// File: tb/ext_irq_selector_test.sv
module ext_irq_selector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_in = '0;
    logic [1:0] ser_pulse = '0, tmr_pulse = '0, bcol_pulse = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, ack = '0;
    logic [7:0] rd_data, req;
    logic       cfg_err;

    int cyc = 0, nchk = 0, nfail = 0;
    bit done = 0;
    logic [7:0] exp_req = '0;
    logic       exp_err = 1'b0;

    // Scoreboard queues.
    int         q_due[$];
    logic [7:0] q_rd[$], q_req[$];
    logic       q_err[$];
    string      q_tag[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    ext_irq_selector uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ser_pulse(ser_pulse),
        .tmr_pulse(tmr_pulse), .bcol_pulse(bcol_pulse), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ack(ack), .req(req), .cfg_err(cfg_err)
    );

    // Monitor: pop due items and compare at the falling edge.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            int d; logic [7:0] er, eq; logic ee; string t;
            d = q_due.pop_front(); er = q_rd.pop_front(); eq = q_req.pop_front();
            ee = q_err.pop_front(); t = q_tag.pop_front();
            nchk++;
            if (rd_data !== er || req !== eq || cfg_err !== ee) begin
                nfail++;
                $display("FAIL %s: rd=%h req=%b err=%b, expected rd=%h req=%b err=%b",
                         t, rd_data, req, cfg_err, er, eq, ee);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk(input string tag, input logic [3:0] a, input logic [7:0] rd_exp);
        rd_addr = a;
        q_due.push_back(cyc); q_rd.push_back(rd_exp); q_req.push_back(exp_req);
        q_err.push_back(exp_err); q_tag.push_back(tag);
        step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pin(input int i, input logic v);
        pin_in[i] = v;
        repeat (3) step();
    endtask

    task automatic ackp(input int k);
        ack[k] = 1'b1; step(); ack[k] = 1'b0;
        exp_req[k] = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        chk("R1", 4'd0, 8'h00);
        chk("R1", 4'd1, 8'h00);
        chk("R1", 4'd2, 8'h00);

        // R2: polarity 0 -> falling only
        pin(0, 1'b1);            chk("R2", 4'd2, 8'h00);
        pin(0, 1'b0);            exp_req[0] = 1; chk("R2", 4'd2, 8'h01);
        // R8: write 1 keeps, write 0 clears
        wr(4'd2, 8'h01);         chk("R8", 4'd2, 8'h01);
        wr(4'd2, 8'h00);         exp_req[0] = 0; chk("R8", 4'd2, 8'h00);
        // R2: polarity 1 -> rising only
        wr(4'd3, 8'h02);
        pin(1, 1'b1);            exp_req[1] = 1; chk("R2", 4'd3, 8'h03);
        ackp(1);                 chk("R8", 4'd3, 8'h02);
        pin(1, 1'b0);            chk("R2", 4'd3, 8'h02);

        // R3: both-edge mode on pin 2
        wr(4'd0, 8'h04);         chk("R3", 4'd0, 8'h04);
        pin(2, 1'b1);            exp_req[2] = 1; chk("R3", 4'd4, 8'h01);
        ackp(2);
        pin(2, 1'b0);            exp_req[2] = 1; chk("R3", 4'd4, 8'h01);
        // R4: both-edge with polarity 1
        wr(4'd4, 8'h02);         exp_req[2] = 0; exp_err = 1; chk("R4", 4'd4, 8'h02);
        wr(4'd4, 8'h00);         exp_err = 0; chk("R4", 4'd4, 8'h00);

        // R5: slot 4 on serial source, pin ignored
        ser_pulse[0] = 1; step(); ser_pulse[0] = 0;
        exp_req[4] = 1;          chk("R5", 4'd6, 8'h01);
        ackp(4);
        pin(4, 1'b1); pin(4, 1'b0); chk("R5", 4'd6, 8'h00);
        // R10: switching select sets a spurious request
        wr(4'd0, 8'h44);         exp_req[4] = 1; chk("R10", 4'd0, 8'h44);
        ackp(4);
        wr(4'd0, 8'h44);         chk("R10", 4'd6, 8'h00);
        // R5: slot 4 on pin 4, serial ignored
        pin(4, 1'b1); pin(4, 1'b0); exp_req[4] = 1; chk("R5", 4'd6, 8'h01);
        ackp(4);
        ser_pulse[0] = 1; step(); ser_pulse[0] = 0; chk("R5", 4'd6, 8'h00);
        // R4: serial source on slot 5 with polarity 1
        wr(4'd7, 8'h02);         exp_err = 1; chk("R4", 4'd7, 8'h02);
        wr(4'd7, 8'h00);         exp_err = 0; chk("R4", 4'd7, 8'h00);

        // R6: slot 6 timer source, collision ignored
        tmr_pulse[0] = 1; step(); tmr_pulse[0] = 0;
        exp_req[6] = 1;          chk("R6", 4'd8, 8'h01);
        ackp(6);
        bcol_pulse[0] = 1; step(); bcol_pulse[0] = 0; chk("R6", 4'd8, 8'h00);
        wr(4'd1, 8'h40);         exp_req[6] = 1; chk("R10", 4'd1, 8'h40);
        wr(4'd8, 8'h00);         exp_req[6] = 0;
        bcol_pulse[0] = 1; step(); bcol_pulse[0] = 0;
        exp_req[6] = 1;          chk("R6", 4'd8, 8'h01);
        ackp(6);
        tmr_pulse[0] = 1; step(); tmr_pulse[0] = 0; chk("R6", 4'd8, 8'h00);
        tmr_pulse[1] = 1; step(); tmr_pulse[1] = 0;
        exp_req[7] = 1;          chk("R6", 4'd9, 8'h01);

        // R7: unused bits and unmapped addresses
        wr(4'd1, 8'hFF);         chk("R7", 4'd1, 8'hC0);
        chk("R7", 4'd12, 8'h00);
        wr(4'd9, 8'h00);         exp_req[7] = 0;

        // R9: event and clear in the same cycle
        ser_pulse[1] = 1; wr_en = 1; wr_addr = 4'd7; wr_data = 8'h00;
        step(); ser_pulse[1] = 0; wr_en = 0;
        exp_req[5] = 1;          chk("R9", 4'd7, 8'h01);
        ser_pulse[1] = 1; ack[5] = 1; step(); ser_pulse[1] = 0; ack[5] = 0;
        chk("R9", 4'd7, 8'h01);
        ackp(5);

        // R11: one request per edge
        pin(3, 1'b1); pin(3, 1'b0); exp_req[3] = 1; chk("R11", 4'd5, 8'h01);
        ackp(3);
        repeat (4) step();
        chk("R11", 4'd5, 8'h00);

        repeat (2) step();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule